// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block tracks whether each of a CAN controller's transmit message buffers is empty or loaded. For each buffer it also keeps an interrupt enable, an abort request and an abort acknowledge. The host loads a buffer and then hands it to the transmitter by writing a one to that buffer's empty flag, which clears the flag. The transmit engine hands a buffer back by reporting one of two events:

- a completed send, or
- a completed abort of a pending request.

Each of these events sets the flag again. Every change of a flag also clears the abort bit that no longer applies to that buffer.

Two mode inputs override normal operation. While initialization is both requested and acknowledged, every buffer is forced empty and the abort state is wiped. While listen mode is active, the host cannot hand buffers over and no transmission is requested.

The block drives three kinds of output:

- one registered interrupt per buffer, plus their OR;
- one transmission request per buffer;
- one access-blocked indication per buffer, for the buffer storage logic.

Top module: `can_txbuf_status`

## Requirements
- R1: After reset every empty flag is 1, and all enables, abort requests and abort acknowledges are 0. Register reads place the per-buffer bits at bit positions 0 to NBUF-1 (bit i is buffer i), and all higher bits read 0. The register selects are: address 0 empty flags, address 1 interrupt enables, address 2 abort requests, address 3 abort acknowledges.
- R2: A host write to address 0 clears each empty flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R3: A send-complete pulse for a buffer sets its empty flag on the next clock.
- R4: An abort-complete pulse for a buffer that is full and has an abort request pending sets its empty flag and its abort acknowledge. An abort-complete pulse without such a pending request changes nothing.
- R5: Whenever an empty flag is set by the engine, the abort request of that buffer is cleared.
- R6: Whenever an empty flag is cleared by the host, the abort acknowledge of that buffer is cleared.
- R7: If an engine set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R8: While listen mode is high, host writes do not clear any empty flag, and every transmission request output is 0.
- R9: While both initialization inputs are high, all empty flags are held at 1 and all abort bits at 0. While either initialization input is high, writes to addresses 0 and 2 are ignored. Writes to address 1 are always accepted.
- R10: Each interrupt output equals the AND of that buffer's empty flag and enable as they stood one cycle earlier. The combined interrupt is the OR of the same per-buffer terms, with the same one-cycle delay.
- R11: The access-blocked output of a buffer is 1 exactly when its empty flag is 0 and the engine reports it as scheduled.
- R12: A host write to address 2 sets the abort request of each buffer whose data bit is 1, but only for buffers that are full. Data bits of 0 leave requests unchanged, and requests for empty buffers are not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialization requested |
| init_ack | input | 1 | Initialization acknowledged |
| listen_mode | input | 1 | Listen-only mode |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data for reg_addr |
| tx_done | input | NBUF | Per-buffer send-complete pulse |
| abort_done | input | NBUF | Per-buffer abort-complete pulse |
| sched | input | NBUF | Per-buffer scheduled indication from the engine |
| tx_req | output | NBUF | Per-buffer transmission request |
| buf_blocked | output | NBUF | Per-buffer storage access blocked |
| irq | output | NBUF | Registered per-buffer transmit interrupt |
| irq_any | output | 1 | Registered OR of the per-buffer interrupts |

## Verification
The bench builds the block with its defaults: three buffers and an 8-bit data path. With these values every flag, enable and abort bit can be driven and read back individually. The five unused upper data bits are also exercised, so reads of zero above the buffer field are checked. Three buffers are enough to hold one buffer in each of the empty, full-with-abort and full-idle states at the same time. This lets the bench show that set, clear and cross-clear events on one buffer leave its neighbours untouched.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EMPTY = 2'd0,
    SEL_IE    = 2'd1,
    SEL_ABRQ  = 2'd2,
    SEL_ABAK  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic flag_clr;
    logic abrq_set;
    logic ie_load;
  } wr_strobe_t;
endpackage

// File: rtl/can_txbuf_regif.sv
module can_txbuf_regif
  import can_txbuf_pkg::*;
#(
  parameter int unsigned NBUF = 3,
  parameter int unsigned DW   = 8
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_ok,
  input  logic [NBUF-1:0]   empty,
  input  logic [NBUF-1:0]   ie,
  input  logic [NBUF-1:0]   abrq,
  input  logic [NBUF-1:0]   abak,
  output wr_strobe_t        strobe,
  output logic [DW-1:0]     rdata
);
  localparam int unsigned PAD = DW - NBUF;

  reg_sel_e         sel;
  logic [NBUF-1:0]  field;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    strobe.flag_clr = reg_wr && wr_ok && (sel == SEL_EMPTY);
    strobe.abrq_set = reg_wr && wr_ok && (sel == SEL_ABRQ);
    strobe.ie_load  = reg_wr && (sel == SEL_IE);
  end

  always_comb begin
    unique case (sel)
      SEL_EMPTY: field = empty;
      SEL_IE:    field = ie;
      SEL_ABRQ:  field = abrq;
      SEL_ABAK:  field = abak;
      default:   field = '0;
    endcase
  end

  assign rdata = {{PAD{1'b0}}, field};
endmodule

// File: rtl/can_txbuf_slot.sv
module can_txbuf_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_init,
  input  logic host_clr,
  input  logic host_abrq,
  input  logic send_done,
  input  logic abrt_done,
  output logic empty,
  output logic abrq,
  output logic abak
);
  logic empty_q, abrq_q, abak_q;
  logic empty_d, abrq_d, abak_d;
  logic abort_ok, hw_set, clr_eff, rq_eff, en;

  always_comb begin
    abort_ok = abrt_done && abrq_q && !empty_q;
    hw_set   = send_done || abort_ok;
    clr_eff  = host_clr && empty_q && !hw_set;
    rq_eff   = host_abrq && !empty_q && !hw_set;
    en       = hold_init || hw_set || clr_eff || rq_eff;
  end

  always_comb begin
    empty_d = empty_q;
    abrq_d  = abrq_q;
    abak_d  = abak_q;
    if (hold_init) begin
      empty_d = 1'b1;
      abrq_d  = 1'b0;
      abak_d  = 1'b0;
    end else if (hw_set) begin
      empty_d = 1'b1;
      abrq_d  = 1'b0;
      if (abort_ok) abak_d = 1'b1;
    end else begin
      if (clr_eff) begin
        empty_d = 1'b0;
        abak_d  = 1'b0;
      end
      if (rq_eff) abrq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      abrq_q  <= 1'b0;
      abak_q  <= 1'b0;
    end else if (en) begin
      empty_q <= empty_d;
      abrq_q  <= abrq_d;
      abak_q  <= abak_d;
    end
  end

  assign empty = empty_q;
  assign abrq  = abrq_q;
  assign abak  = abak_q;
endmodule

// File: rtl/can_txbuf_irq.sv
module can_txbuf_irq #(
  parameter int unsigned NBUF = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ie_load,
  input  logic [NBUF-1:0] ie_wdata,
  input  logic [NBUF-1:0] empty,
  output logic [NBUF-1:0] ie,
  output logic [NBUF-1:0] irq,
  output logic            irq_any
);
  logic [NBUF-1:0] ie_q, ie_d;
  logic [NBUF-1:0] irq_q, irq_d;
  logic            any_q, any_d;

  always_comb begin
    ie_d  = ie_load ? ie_wdata : ie_q;
    irq_d = empty & ie_q;
    any_d = |irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_load) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      any_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      any_q <= any_d;
    end
  end

  assign ie      = ie_q;
  assign irq     = irq_q;
  assign irq_any = any_q;
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
  import can_txbuf_pkg::*;
#(
  parameter int unsigned NBUF = 3,
  parameter int unsigned DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              listen_mode,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NBUF-1:0]   tx_done,
  input  logic [NBUF-1:0]   abort_done,
  input  logic [NBUF-1:0]   sched,
  output logic [NBUF-1:0]   tx_req,
  output logic [NBUF-1:0]   buf_blocked,
  output logic [NBUF-1:0]   irq,
  output logic              irq_any
);
  logic            wr_ok, hold_init;
  wr_strobe_t      strobe;
  logic [NBUF-1:0] empty_w, abrq_w, abak_w, ie_w;
  logic [NBUF-1:0] wbits;
  logic            unused_hi;

  assign wr_ok     = !init_req && !init_ack;
  assign hold_init = init_req && init_ack;
  assign wbits     = reg_wdata[NBUF-1:0];
  assign unused_hi = ^reg_wdata[DW-1:NBUF];

  can_txbuf_regif #(.NBUF(NBUF), .DW(DW)) u_regif (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wr_ok    (wr_ok),
    .empty    (empty_w),
    .ie       (ie_w),
    .abrq     (abrq_w),
    .abak     (abak_w),
    .strobe   (strobe),
    .rdata    (reg_rdata)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    can_txbuf_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_init (hold_init),
      .host_clr  (strobe.flag_clr && wbits[g] && !listen_mode),
      .host_abrq (strobe.abrq_set && wbits[g]),
      .send_done (tx_done[g]),
      .abrt_done (abort_done[g]),
      .empty     (empty_w[g]),
      .abrq      (abrq_w[g]),
      .abak      (abak_w[g])
    );
  end

  can_txbuf_irq #(.NBUF(NBUF)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ie_load  (strobe.ie_load),
    .ie_wdata (wbits),
    .empty    (empty_w),
    .ie       (ie_w),
    .irq      (irq),
    .irq_any  (irq_any)
  );

  assign tx_req      = ~empty_w & {NBUF{!listen_mode}};
  assign buf_blocked = ~empty_w & sched;
endmodule

// File: rtl/can_txbuf_status_chk.sv
module can_txbuf_status_chk #(
  parameter int unsigned NBUF = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init_req,
  input logic            init_ack,
  input logic            listen_mode,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [NBUF-1:0] wbits,
  input logic [NBUF-1:0] tx_done,
  input logic [NBUF-1:0] empty,
  input logic [NBUF-1:0] abrq,
  input logic [NBUF-1:0] abak,
  input logic [NBUF-1:0] ie,
  input logic [NBUF-1:0] irq,
  input logic            irq_any
);
  for (genvar g = 0; g < NBUF; g++) begin : g_bit
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && wbits[g] && !init_req && !init_ack &&
       !listen_mode && empty[g] && !tx_done[g]) |=> !empty[g]);

    p_send_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[g] |=> empty[g]);

    p_set_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty[g]) |-> !abrq[g]);

    p_clr_drops_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(empty[g]) |-> !abak[g]);

    p_listen_no_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      listen_mode |=> !$fell(empty[g]));

    p_req_only_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abrq[g]) |-> !empty[g]);
  end

  p_init_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (&empty && abrq == '0 && abak == '0));

  p_irq_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(empty & ie)));

  p_irq_any_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_any == |$past(empty & ie)));
endmodule

bind can_txbuf_status can_txbuf_status_chk #(.NBUF(NBUF)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_req    (init_req),
  .init_ack    (init_ack),
  .listen_mode (listen_mode),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .wbits       (reg_wdata[NBUF-1:0]),
  .tx_done     (tx_done),
  .empty       (empty_w),
  .abrq        (abrq_w),
  .abak        (abak_w),
  .ie          (ie_w),
  .irq         (irq),
  .irq_any     (irq_any)
);

// File: tb/can_txbuf_status_tb.sv
module can_txbuf_status_tb;
  localparam int NB = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          init_req, init_ack, listen_mode, reg_wr;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic [NB-1:0] tx_done, abort_done, sched, tx_req, buf_blocked, irq;
  logic          irq_any;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_e[NB], m_rq[NB], m_ak[NB], m_ie[NB], m_irq[NB];
  bit m_any;

  always #5 clk = ~clk;

  can_txbuf_status #(.NBUF(NB), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
    .listen_mode(listen_mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_done(tx_done),
    .abort_done(abort_done), .sched(sched), .tx_req(tx_req),
    .buf_blocked(buf_blocked), .irq(irq), .irq_any(irq_any)
  );

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pack(input int sel);
    int v = 0;
    for (int i = 0; i < NB; i++) begin
      case (sel)
        0: v |= int'(m_e[i]) << i;
        1: v |= int'(m_ie[i]) << i;
        2: v |= int'(m_rq[i]) << i;
        default: v |= int'(m_ak[i]) << i;
      endcase
    end
    return v;
  endfunction

  task automatic compare_all();
    int exp_tx = 0, exp_blk = 0, exp_irq = 0;
    for (int i = 0; i < NB; i++) begin
      if (!m_e[i] && !listen_mode) exp_tx |= 1 << i;
      if (!m_e[i] && sched[i]) exp_blk |= 1 << i;
      if (m_irq[i]) exp_irq |= 1 << i;
    end
    chk("rdata", int'(reg_rdata), pack(int'(reg_addr)));
    chk("tx_req", int'(tx_req), exp_tx);
    chk("buf_blocked", int'(buf_blocked), exp_blk);
    chk("irq", int'(irq), exp_irq);
    chk("irq_any", int'(irq_any), int'(m_any));
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin
      m_e[i] = 1; m_rq[i] = 0; m_ak[i] = 0; m_ie[i] = 0; m_irq[i] = 0;
    end
    m_any = 0;
  endtask

  task automatic model_step();
    bit held = init_req && init_ack;
    bit can_wr = !init_req && !init_ack;
    m_any = 0;
    for (int i = 0; i < NB; i++) begin
      m_irq[i] = m_e[i] && m_ie[i];
      if (m_irq[i]) m_any = 1;
    end
    for (int i = 0; i < NB; i++) begin
      bit aborted = abort_done[i] && m_rq[i] && !m_e[i];
      bit set_now = tx_done[i] || aborted;
      if (held) begin
        m_e[i] = 1; m_rq[i] = 0; m_ak[i] = 0;
      end else if (set_now) begin
        m_e[i] = 1; m_rq[i] = 0;
        if (aborted) m_ak[i] = 1;
      end else begin
        bit was_empty = m_e[i];
        if (reg_wr && can_wr && reg_addr == 0 && reg_wdata[i] && !listen_mode && was_empty) begin
          m_e[i] = 0; m_ak[i] = 0;
        end
        if (reg_wr && can_wr && reg_addr == 2 && reg_wdata[i] && !was_empty) m_rq[i] = 1;
      end
    end
    if (reg_wr && reg_addr == 1)
      for (int i = 0; i < NB; i++) m_ie[i] = reg_wdata[i];
  endtask

  // one clock: drive at the falling edge, compare, then advance the model
  task automatic cyc(input bit wr, input int addr, input int wd,
                     input int txd, input int abd, input int sch,
                     input bit lst, input bit ir, input bit ia);
    @(negedge clk);
    reg_wr = wr; reg_addr = 2'(addr); reg_wdata = DW'(wd);
    tx_done = NB'(txd); abort_done = NB'(abd); sched = NB'(sch);
    listen_mode = lst; init_req = ir; init_ack = ia;
    #1;
    compare_all();
    @(posedge clk);
    model_step();
  endtask

  task automatic rd(input int addr);
    cyc(0, addr, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; tx_done = 0;
    abort_done = 0; sched = 0; listen_mode = 0; init_req = 0; init_ack = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset values of every register, upper bits zero
    tag = "R1";
    for (int a = 0; a < 4; a++) rd(a);

    // R10: enable all, interrupts follow one cycle later
    tag = "R10";
    cyc(1, 1, 8'hF7, 0, 0, 0, 0, 0, 0);
    rd(1); rd(1);

    // R2: clear flags 0 and 2, then a zero write changes nothing
    tag = "R2";
    cyc(1, 0, 8'hF5, 0, 0, 0, 0, 0, 0);
    rd(0);
    cyc(1, 0, 8'h00, 0, 0, 0, 0, 0, 0);
    rd(0);

    // R11: blocked only where full and scheduled
    tag = "R11";
    cyc(0, 0, 0, 0, 0, 3'b111, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'b010, 0, 0, 0);

    // R12: abort request sets only for full buffers
    tag = "R12";
    cyc(1, 2, 8'h07, 0, 0, 0, 0, 0, 0);
    rd(2);

    // R4: abort of buffer 0 completes; abort pulse on empty buffer 1 ignored
    tag = "R4";
    cyc(0, 3, 0, 0, 3'b011, 0, 0, 0, 0);
    rd(3); rd(0);
    // R5: request bit dropped on set
    tag = "R5";
    rd(2);

    // R3: send complete on buffer 2 (also drops its request, R5)
    tag = "R3";
    cyc(0, 2, 0, 3'b100, 0, 0, 0, 0, 0);
    rd(0); rd(2);

    // R6: clearing flag 0 drops its acknowledge
    tag = "R6";
    cyc(1, 0, 8'h01, 0, 0, 0, 0, 0, 0);
    rd(3); rd(0);

    // R7: host clear and send complete on buffer 1 together
    tag = "R7";
    cyc(1, 0, 8'h02, 3'b010, 0, 0, 0, 0, 0);
    rd(0);

    // R8: listen mode blocks clears and transmission requests
    tag = "R8";
    cyc(1, 0, 8'h07, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    rd(0);

    // R9: single init input blocks writes; both force empty
    tag = "R9";
    cyc(1, 0, 8'h06, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 8'h06, 0, 0, 0, 0, 0, 1);
    cyc(1, 1, 8'h02, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 8'h06, 0, 0, 0, 0, 0, 0);
    cyc(1, 2, 8'h06, 0, 0, 0, 0, 0, 0);
    cyc(0, 2, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
    for (int a = 0; a < 4; a++) rd(a);

    // mixed traffic across all requirements
    tag = "R2/R12 mixed";
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      cyc(op < 5, (op < 3) ? 0 : int'($urandom_range(0, 3)),
          int'($urandom), ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : 0,
          ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 7)) : 0,
          int'($urandom_range(0, 7)), $urandom_range(0, 7) == 0,
          $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
    end

    finish_run();
  end
endmodule